// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames on a single input line in which a ninth bit, sent after the eight data bits, marks the frame as a station address (ID) or as ordinary data. The line idles high. Each frame has a low start bit, eight data bits with the least significant bit first, the address-marker bit, and one high stop bit. A baud tick at sixteen times the bit rate drives the sampling. A falling edge on the line is confirmed as a start bit at its middle, and every later bit is sampled at its middle.

A filter flag set by software makes the receiver drop every data frame (marker bit 0) until an ID frame (marker bit 1) arrives. The ID frame is stored and raises its own interrupt pulse. It also clears the filter flag, so that the data frames that follow are accepted. When the filter is off, every good frame is stored and raises the ordinary receive interrupt. Software empties the receive register by strobing the full-flag clear. Framing errors and overruns are kept as sticky flags.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, rx_data is 0 and rx_full, last_mpb, mpie, frame_err, overrun, rxi_irq and mpi_irq are all 0.
- R2: A frame is a start bit of 0, data bits D0..D7 (D0 first, D0 lands in rx_data[0]), the marker bit and a stop bit of 1. The stored byte goes to rx_data and the marker bit to last_mpb. With the default two synchronizer stages, the flags change at the 172nd clock edge after rxd falls, counting the edge at which the low level is first captured as edge 1, with the tick high on every cycle.
- R3: A low pulse on rxd that has returned high before the middle of the start bit (8 ticks) starts no frame and changes no output.
- R4: While mpie is 0, every good frame with rx_full clear is stored, sets rx_full and gives a one-cycle rxi_irq pulse, whatever its marker bit.
- R5: While mpie is 1, a good frame with marker bit 0 changes no output: rx_data, rx_full, last_mpb, mpie and the interrupts stay as they were.
- R6: While mpie is 1, a good frame with marker bit 1 is stored, sets rx_full and last_mpb, gives a one-cycle mpi_irq pulse and no rxi_irq pulse, and clears mpie.
- R7: A one-cycle clr_full strobe clears rx_full. If a frame is accepted in that same cycle, it is stored and rx_full stays set.
- R8: A frame whose stop bit is sampled as 0 sets frame_err and changes neither rx_full nor rx_data. A clr_err strobe clears frame_err and overrun.
- R9: A frame that would be stored while rx_full is set sets overrun, leaves rx_data, last_mpb and rx_full unchanged, and raises no interrupt.
- R10: A mpie_wr strobe loads mpie_wdata into mpie. This write takes priority over the clearing of mpie by an ID frame in the same cycle.
- R11: rxi_irq and mpi_irq are never high together, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial input line, idle high |
| clr_full | input | 1 | Strobe: clear rx_full |
| clr_err | input | 1 | Strobe: clear frame_err and overrun |
| mpie_wr | input | 1 | Strobe: write the filter flag |
| mpie_wdata | input | 1 | Value written to the filter flag |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive register holds unread data |
| last_mpb | output | 1 | Marker bit of the last stored frame |
| mpie | output | 1 | Filter flag: drop data frames until an ID frame |
| frame_err | output | 1 | Sticky framing error |
| overrun | output | 1 | Sticky overrun |
| rxi_irq | output | 1 | Pulse: frame stored with the filter off |
| mpi_irq | output | 1 | Pulse: ID frame stored with the filter on |

## Verification
The assertions assume that software strobes arrive only as single-cycle pulses and that rxd holds each bit level for a whole bit time of sixteen ticks. Under that assumption a stored byte can never appear without one of the two interrupt pulses. The stimulus holds every bit for exactly sixteen clock cycles with the tick high on every cycle. It issues strobes only in quiet gaps between frames, well away from the cycle in which a frame completes, so the mid-bit sampling and the flag priorities stay inside what the properties take for granted. The glitch test returns the line high after four cycles, well before the start-bit check at the middle of the bit.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2
   } rx_state_e;

   typedef struct packed {
      logic [7:0] data;
      logic       mpb;
      logic       stop_ok;
   } rx_frame_t;

endpackage

// File: rtl/mpuart_sync.sv
module mpuart_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial begin
      if (STAGES < 2) $error("mpuart_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpuart_framer.sv
module mpuart_framer
   import mpuart_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rxs,
   output logic      done,
   output rx_frame_t frame
);
   localparam int CNT_W    = $clog2(OVS);
   localparam int HALF     = OVS / 2;
   localparam int LAST_BIT = DATA_W + 1;
   localparam int BIT_W    = $clog2(LAST_BIT + 1);

   initial begin
      if (OVS < 4 || (OVS % 2) != 0) $error("mpuart_framer: OVS must be even and >= 4");
      if (DATA_W != 8) $error("mpuart_framer: DATA_W must be 8");
   end

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bit_idx;
   logic [DATA_W-1:0] shreg;
   logic              mpb_q;
   logic              stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         mpb_q   <= 1'b0;
         stop_q  <= 1'b1;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!rxs) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == CNT_W'(HALF - 1)) begin
                     cnt     <= '0;
                     bit_idx <= '0;
                     state   <= rxs ? RX_IDLE : RX_BITS;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (cnt == CNT_W'(OVS - 1)) begin
                     cnt <= '0;
                     if (bit_idx < BIT_W'(DATA_W)) begin
                        shreg <= {rxs, shreg[DATA_W-1:1]};
                     end else if (bit_idx == BIT_W'(DATA_W)) begin
                        mpb_q <= rxs;
                     end else begin
                        stop_q <= rxs;
                     end
                     if (bit_idx == BIT_W'(LAST_BIT)) begin
                        done  <= 1'b1;
                        state <= RX_IDLE;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assign frame.data    = shreg;
   assign frame.mpb     = mpb_q;
   assign frame.stop_ok = stop_q;

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_START) |-> (cnt < CNT_W'(HALF)));

   // R3
   start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_IDLE && tick && rxs) |=> (state == RX_IDLE));
endmodule

// File: rtl/mpuart_filter.sv
module mpuart_filter
   import mpuart_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  rx_frame_t         frame,
   input  logic              clr_full,
   input  logic              clr_err,
   input  logic              mpie_wr,
   input  logic              mpie_wdata,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              last_mpb,
   output logic              mpie,
   output logic              frame_err,
   output logic              overrun,
   output logic              rxi_irq,
   output logic              mpi_irq
);
   logic full_after_clr;
   logic good;
   logic dropped;
   logic wanted;
   logic store;

   assign full_after_clr = rx_full & ~clr_full;
   assign good    = done & frame.stop_ok;
   assign dropped = mpie & ~frame.mpb;
   assign wanted  = good & ~dropped;
   assign store   = wanted & ~full_after_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data   <= '0;
         rx_full   <= 1'b0;
         last_mpb  <= 1'b0;
         mpie      <= 1'b0;
         frame_err <= 1'b0;
         overrun   <= 1'b0;
         rxi_irq   <= 1'b0;
         mpi_irq   <= 1'b0;
      end else begin
         rxi_irq <= 1'b0;
         mpi_irq <= 1'b0;
         rx_full <= full_after_clr;
         if (clr_err) begin
            frame_err <= 1'b0;
            overrun   <= 1'b0;
         end
         if (done && !frame.stop_ok) frame_err <= 1'b1;
         if (wanted && full_after_clr) overrun <= 1'b1;
         if (store) begin
            rx_data  <= frame.data;
            rx_full  <= 1'b1;
            last_mpb <= frame.mpb;
            if (mpie) begin
               mpie    <= 1'b0;
               mpi_irq <= 1'b1;
            end else begin
               rxi_irq <= 1'b1;
            end
         end
         if (mpie_wr) mpie <= mpie_wdata;
      end
   end

   // R11
   irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rxi_irq && mpi_irq));

   // R11
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxi_irq || mpi_irq) |=> !(rxi_irq || mpi_irq));

   // R4
   full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> (rxi_irq || mpi_irq));

   // R6
   id_mpb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mpi_irq |-> (last_mpb && rx_full));

   // R9
   overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> ($stable(rx_data) && !rxi_irq && !mpi_irq));

   // R8
   ferr_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> !$rose(rx_full));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
   import mpuart_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rxd,
   input  logic              clr_full,
   input  logic              clr_err,
   input  logic              mpie_wr,
   input  logic              mpie_wdata,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              last_mpb,
   output logic              mpie,
   output logic              frame_err,
   output logic              overrun,
   output logic              rxi_irq,
   output logic              mpi_irq
);
   logic      rxs;
   logic      frm_done;
   rx_frame_t frm;

   mpuart_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (rxs)
   );

   mpuart_framer #(.OVS(OVS), .DATA_W(DATA_W)) u_framer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (baud_tick),
      .rxs  (rxs),
      .done (frm_done),
      .frame(frm)
   );

   mpuart_filter #(.DATA_W(DATA_W)) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (frm_done),
      .frame     (frm),
      .clr_full  (clr_full),
      .clr_err   (clr_err),
      .mpie_wr   (mpie_wr),
      .mpie_wdata(mpie_wdata),
      .rx_data   (rx_data),
      .rx_full   (rx_full),
      .last_mpb  (last_mpb),
      .mpie      (mpie),
      .frame_err (frame_err),
      .overrun   (overrun),
      .rxi_irq   (rxi_irq),
      .mpi_irq   (mpi_irq)
   );
endmodule

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic       rxd = 1'b1;
   logic       clr_full = 1'b0;
   logic       clr_err = 1'b0;
   logic       mpie_wr = 1'b0;
   logic       mpie_wdata = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, last_mpb, mpie, frame_err, overrun, rxi_irq, mpi_irq;

   mp_uart_rx dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
      .clr_full(clr_full), .clr_err(clr_err), .mpie_wr(mpie_wr), .mpie_wdata(mpie_wdata),
      .rx_data(rx_data), .rx_full(rx_full), .last_mpb(last_mpb), .mpie(mpie),
      .frame_err(frame_err), .overrun(overrun), .rxi_irq(rxi_irq), .mpi_irq(mpi_irq)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int pos_cnt = 0;
   int seen_rxi = 0;
   int seen_mpi = 0;

   typedef struct {
      int due;
      int d;
      int mpb;
      int stop;
   } ev_t;
   ev_t evq[$];

   int m_data, m_full, m_lmpb, m_mpie, m_ferr, m_ovr, m_rxi, m_mpi;

   // Reference model: updated at each rising edge from the inputs and the queued frames.
   always @(posedge clk) begin
      pos_cnt = pos_cnt + 1;
      if (!rst_n) begin
         m_data = 0; m_full = 0; m_lmpb = 0; m_mpie = 0;
         m_ferr = 0; m_ovr = 0; m_rxi = 0; m_mpi = 0;
      end else begin
         m_rxi = 0;
         m_mpi = 0;
         if (clr_full) m_full = 0;
         if (clr_err) begin m_ferr = 0; m_ovr = 0; end
         if (evq.size() > 0 && evq[0].due == pos_cnt) begin
            ev_t e;
            e = evq.pop_front();
            if (e.stop == 0) m_ferr = 1;
            else if (m_mpie == 1 && e.mpb == 0) begin end
            else if (m_full == 1) m_ovr = 1;
            else begin
               m_data = e.d; m_full = 1; m_lmpb = e.mpb;
               if (m_mpie == 1) begin m_mpie = 0; m_mpi = 1; end
               else m_rxi = 1;
            end
         end
         if (mpie_wr) m_mpie = int'(mpie_wdata);
      end
   end

   // Per-cycle comparison away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (rxi_irq) seen_rxi++;
         if (mpi_irq) seen_mpi++;
         if (int'(rx_data) != m_data) begin errors++; $display("FAIL R2 rx_data act=%0h exp=%0h", rx_data, m_data); end
         if (int'(rx_full) != m_full) begin errors++; $display("FAIL R4 rx_full act=%0d exp=%0d", rx_full, m_full); end
         if (int'(last_mpb) != m_lmpb) begin errors++; $display("FAIL R6 last_mpb act=%0d exp=%0d", last_mpb, m_lmpb); end
         if (int'(mpie) != m_mpie) begin errors++; $display("FAIL R10 mpie act=%0d exp=%0d", mpie, m_mpie); end
         if (int'(frame_err) != m_ferr) begin errors++; $display("FAIL R8 frame_err act=%0d exp=%0d", frame_err, m_ferr); end
         if (int'(overrun) != m_ovr) begin errors++; $display("FAIL R9 overrun act=%0d exp=%0d", overrun, m_ovr); end
         if (int'(rxi_irq) != m_rxi) begin errors++; $display("FAIL R11 rxi_irq act=%0d exp=%0d", rxi_irq, m_rxi); end
         if (int'(mpi_irq) != m_mpi) begin errors++; $display("FAIL R11 mpi_irq act=%0d exp=%0d", mpi_irq, m_mpi); end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      @(negedge clk);
      rxd = v;
      repeat (15) @(negedge clk);
   endtask

   task automatic send(input int d, input int mpb, input int stop);
      ev_t e;
      @(negedge clk);
      rxd = 1'b0;
      e.due = pos_cnt + 172; e.d = d; e.mpb = mpb; e.stop = stop;
      evq.push_back(e);
      repeat (15) @(negedge clk);
      for (int i = 0; i < 8; i++) hold_bit(logic'((d >> i) & 1));
      hold_bit(logic'(mpb));
      hold_bit(logic'(stop));
      @(negedge clk);
      rxd = 1'b1;
      repeat (30) @(negedge clk);
   endtask

   task automatic strobe_clr_full();
      @(negedge clk); clr_full = 1'b1;
      @(negedge clk); clr_full = 1'b0;
   endtask

   task automatic strobe_clr_err();
      @(negedge clk); clr_err = 1'b1;
      @(negedge clk); clr_err = 1'b0;
   endtask

   task automatic write_mpie(input logic v);
      @(negedge clk); mpie_wr = 1'b1; mpie_wdata = v;
      @(negedge clk); mpie_wr = 1'b0; mpie_wdata = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int r0, m0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rx_data", int'(rx_data), 0);
      chk("R1 flags", int'({rx_full, last_mpb, mpie, frame_err, overrun, rxi_irq, mpi_irq}), 0);

      // R2 R4: filter off, data frame
      r0 = seen_rxi;
      send(8'hA5, 0, 1);
      chk("R2 byte", int'(rx_data), 8'hA5);
      chk("R4 full", int'(rx_full), 1);
      chk("R4 rxi pulse", seen_rxi - r0, 1);
      strobe_clr_full();
      @(negedge clk);
      chk("R7 cleared", int'(rx_full), 0);

      // R4: filter off, marker bit 1 still gives rxi
      r0 = seen_rxi; m0 = seen_mpi;
      send(8'h81, 1, 1);
      chk("R4 id with filter off", seen_rxi - r0, 1);
      chk("R4 no mpi", seen_mpi - m0, 0);
      chk("R2 last_mpb", int'(last_mpb), 1);
      strobe_clr_full();

      // R10 R5: filter on, data frame dropped
      write_mpie(1'b1);
      @(negedge clk);
      chk("R10 mpie set", int'(mpie), 1);
      r0 = seen_rxi;
      send(8'h12, 0, 1);
      chk("R5 no full", int'(rx_full), 0);
      chk("R5 data kept", int'(rx_data), 8'h81);
      chk("R5 no irq", seen_rxi - r0, 0);

      // R6: ID frame
      m0 = seen_mpi; r0 = seen_rxi;
      send(8'h3C, 1, 1);
      chk("R6 byte", int'(rx_data), 8'h3C);
      chk("R6 mpi pulse", seen_mpi - m0, 1);
      chk("R6 no rxi", seen_rxi - r0, 0);
      chk("R6 mpie cleared", int'(mpie), 0);
      strobe_clr_full();

      // R4: following data frame accepted
      send(8'h55, 0, 1);
      chk("R4 after id", int'(rx_data), 8'h55);
      chk("R2 last_mpb zero", int'(last_mpb), 0);

      // R9: overrun while full
      r0 = seen_rxi;
      send(8'hEE, 0, 1);
      chk("R9 overrun", int'(overrun), 1);
      chk("R9 data kept", int'(rx_data), 8'h55);
      chk("R9 no irq", seen_rxi - r0, 0);
      strobe_clr_err();
      @(negedge clk);
      chk("R8 clr_err clears overrun", int'(overrun), 0);
      strobe_clr_full();

      // R8: framing error
      send(8'h77, 0, 0);
      chk("R8 ferr", int'(frame_err), 1);
      chk("R8 no full", int'(rx_full), 0);
      strobe_clr_err();
      @(negedge clk);
      chk("R8 cleared", int'(frame_err), 0);

      // R3: short glitch ignored
      @(negedge clk); rxd = 1'b0;
      repeat (3) @(negedge clk);
      @(negedge clk); rxd = 1'b1;
      repeat (200) @(negedge clk);
      chk("R3 glitch full", int'(rx_full), 0);
      chk("R3 glitch ferr", int'(frame_err), 0);
      chk("R3 glitch data", int'(rx_data), 8'h55);

      // R2: more patterns
      for (int k = 0; k < 4; k++) begin
         int pat;
         pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h01 : 8'h80;
         send(pat, k & 1, 1);
         chk("R2 pattern", int'(rx_data), pat);
         strobe_clr_full();
      end

      // R10: write clears filter flag
      write_mpie(1'b1);
      write_mpie(1'b0);
      @(negedge clk);
      chk("R10 mpie clear", int'(mpie), 0);

      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule